// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This unit sits next to a calendar counter that keeps time in BCD. It holds six alarm bytes, one each for seconds, minutes, hours, day of week, day of month and month. Bit 7 of each byte decides whether that field takes part in the comparison, and bits 6:0 hold the BCD target. On every seconds update from the counter, the unit compares all enabled fields with the current time. If every enabled field is equal, it sets a sticky alarm flag.

Software reaches the alarm bytes and a small control register over a single-cycle register bus. Writes take effect at the clock edge. Read data follows the address combinationally. The interrupt output is the alarm flag gated by an interrupt enable bit in the control register. A clear issued by software in the same cycle as a fresh match loses to the match, so no alarm event is dropped.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset, all six alarm bytes read 0x00, the control register at index 14 reads 0x00, and `alarmIrq` is low.
- R2: The alarm bytes are at register indices 8 to 13, in this order: seconds, minutes, hours, weekday, day of month, month. A write stores the whole byte, and a read of that index returns it unchanged on `busRdData` in the same cycle as the address.
- R3: A field whose byte has bit 7 clear is left out of the match, whatever its bits 6:0 hold. A byte of 0x00 is one such case.
- R4: When `secTick` is high and every enabled field's bits 6:0 equal the matching 7-bit current-time input, the alarm flag (bit 0 of index 14) is 1 from the next clock edge onward.
- R5: If no alarm byte has bit 7 set, the flag is never set, whatever the current time is.
- R6: A match while `secTick` is low does not set the flag.
- R7: The flag is sticky. It goes to 0 only when index 14 is written with bit 0 = 0. Writing bit 0 = 1 leaves the flag unchanged, and later mismatching ticks do not clear it.
- R8: Bit 3 of index 14 is the interrupt enable, which can be read and written. `alarmIrq` is high exactly when both the flag and the enable are 1.
- R9: A write that clears the flag, landing in the same cycle as a tick with a match, leaves the flag at 1.
- R10: A difference in any single enabled field, such as month 0x11 against a target of 0x12, prevents the flag from being set. Month targets use BCD 0x01 to 0x12.
- R11: Indices other than 8 to 14 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register index |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| secTick | input | 1 | One-cycle pulse when the seconds count updates |
| curSec | input | 7 | Current seconds, BCD |
| curMin | input | 7 | Current minutes, BCD |
| curHour | input | 7 | Current hours, BCD |
| curWday | input | 7 | Current weekday, BCD |
| curMday | input | 7 | Current day of month, BCD |
| curMon | input | 7 | Current month, BCD 01 to 12 |
| alarmIrq | output | 1 | Alarm interrupt request |

## Verification
Read data is combinational, so the bench checks a read a fraction of a nanosecond after it changes `busAddr`. A register write is due on a read from the cycle after the edge that captured it. The alarm flag and `alarmIrq` are due right after the edge that samples `secTick` or a control write. Every stimulus is applied at the falling edge, and every result is sampled one nanosecond after the following rising edge. The reference model updates its state at that same edge.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  parameter int ADDR_W     = 4;
  parameter int DATA_W     = 8;
  parameter int TIME_W     = 7;
  parameter int NUM_FIELDS = 6;
  parameter int ALARM_BASE = 8;
  parameter int CTRL_IDX   = 14;
  parameter int FLAG_BIT   = 0;
  parameter int IE_BIT     = 3;
  localparam int EN_BIT    = DATA_W - 1;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrAlarm;
    logic                  wrCtrl;
    logic [NUM_FIELDS-1:0] rdAlarm;
    logic                  rdCtrl;
    logic [DATA_W-1:0]     data;
  } strobe_t;
endpackage

// File: rtl/bcd_alarm_ctrl.sv
module bcd_alarm_ctrl
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output strobe_t           strb
);
  logic [NUM_FIELDS-1:0] hitAlarm;
  logic                  hitCtrl;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign hitAlarm[i] = (busAddr == ADDR_W'(ALARM_BASE + i));
  end
  assign hitCtrl = (busAddr == ADDR_W'(CTRL_IDX));

  always_comb begin
    strb.wrAlarm = hitAlarm & {NUM_FIELDS{busWe}};
    strb.wrCtrl  = hitCtrl & busWe;
    strb.rdAlarm = hitAlarm;
    strb.rdCtrl  = hitCtrl;
    strb.data    = busWrData;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrAlarm, strb.wrCtrl})); // R2
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr < ADDR_W'(ALARM_BASE) || busAddr > ADDR_W'(CTRL_IDX)))
      |-> ($countones({strb.wrAlarm, strb.wrCtrl}) == 0)); // R11
endmodule

// File: rtl/bcd_alarm_dp.sv
module bcd_alarm_dp
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              secTick,
  input  logic [TIME_W-1:0] curTime [NUM_FIELDS],
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq
);
  logic [DATA_W-1:0]     almQ [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldEn;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic                  match;
  logic                  flagQ;
  logic                  ieQ;
  logic                  clrReq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                almQ[i] <= '0;
      else if (strb.wrAlarm[i]) almQ[i] <= strb.data;
    end
    assign fieldEn[i] = almQ[i][EN_BIT];
    assign fieldOk[i] = !fieldEn[i] || (almQ[i][TIME_W-1:0] == curTime[i]);
  end

  assign match  = (|fieldEn) && (&fieldOk);
  assign clrReq = strb.wrCtrl && !strb.data[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flagQ <= 1'b0;
    else if (secTick && match) flagQ <= 1'b1;
    else if (clrReq)           flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ieQ <= 1'b0;
    else if (strb.wrCtrl) ieQ <= strb.data[IE_BIT];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (strb.rdAlarm[i]) rdData = almQ[i];
    if (strb.rdCtrl) begin
      rdData[FLAG_BIT] = flagQ;
      rdData[IE_BIT]   = ieQ;
    end
  end

  assign alarmIrq = flagQ & ieQ;

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && match) |=> flagQ); // R4
  AST_NO_FIELD_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (fieldEn == '0) |-> !match); // R5
  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !secTick) |=> !flagQ); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrReq) |=> flagQ); // R7
  AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && secTick && match) |=> flagQ); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ieQ && !strb.wrCtrl) |=> !alarmIrq); // R8
endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              secTick,
  input  logic [TIME_W-1:0] curSec,
  input  logic [TIME_W-1:0] curMin,
  input  logic [TIME_W-1:0] curHour,
  input  logic [TIME_W-1:0] curWday,
  input  logic [TIME_W-1:0] curMday,
  input  logic [TIME_W-1:0] curMon,
  output logic              alarmIrq
);
  strobe_t           strb;
  logic [TIME_W-1:0] curTime [NUM_FIELDS];

  assign curTime[0] = curSec;
  assign curTime[1] = curMin;
  assign curTime[2] = curHour;
  assign curTime[3] = curWday;
  assign curTime[4] = curMday;
  assign curTime[5] = curMon;

  bcd_alarm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strb      (strb)
  );

  bcd_alarm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .secTick  (secTick),
    .curTime  (curTime),
    .rdData   (busRdData),
    .alarmIrq (alarmIrq)
  );
endmodule

// File: tb/bcd_alarm_unit_tb.sv
`timescale 1ns/1ps
module bcd_alarm_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       secTick = 1'b0;
  logic [6:0] tCur [6];
  logic       alarmIrq;

  logic [7:0] mAlm [6];
  logic       mFlag, mIe;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  bcd_alarm_unit u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .secTick(secTick),
    .curSec(tCur[0]), .curMin(tCur[1]), .curHour(tCur[2]),
    .curWday(tCur[3]), .curMday(tCur[4]), .curMon(tCur[5]),
    .alarmIrq(alarmIrq)
  );

  function automatic logic [6:0] toBcd(input int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit modelMatch();
    bit any = 0;
    bit ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (mAlm[i][7]) begin
        any = 1;
        if (mAlm[i][6:0] != tCur[i]) ok = 0;
      end
    end
    return any && ok;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] addr, input logic [7:0] data, input bit tick);
    bit m;
    @(negedge clk);
    busWe = we; busAddr = addr; busWrData = data; secTick = tick;
    m = modelMatch();
    @(posedge clk);
    #1;
    busWe = 1'b0; secTick = 1'b0;
    if (tick && m) mFlag = 1'b1;
    else if (we && addr == 4'd14 && !data[0]) mFlag = 1'b0;
    if (we && addr == 4'd14) mIe = data[3];
    if (we && addr >= 4'd8 && addr <= 4'd13) mAlm[addr - 4'd8] = data;
  endtask

  task automatic readCheck(input logic [3:0] addr, input logic [7:0] exp, input string tag);
    busAddr = addr;
    #0.2;
    check(busRdData === exp, tag, int'(busRdData), int'(exp));
  endtask

  task automatic stateCheck(input string tag);
    readCheck(4'd14, {4'b0, mIe, 2'b0, mFlag}, tag);
    check(alarmIrq === (mFlag & mIe), {tag, " irq R8"}, int'(alarmIrq), int'(mFlag & mIe));
  endtask

  task automatic setTime(input logic [6:0] s, mi, h, w, d, mo);
    tCur[0] = s; tCur[1] = mi; tCur[2] = h; tCur[3] = w; tCur[4] = d; tCur[5] = mo;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin mAlm[i] = '0; tCur[i] = '0; end
    mFlag = 0; mIe = 0;
    #12 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 0; i < 6; i++) readCheck(4'(8 + i), 8'h00, "R1 alarm reset");
    stateCheck("R1 ctrl reset");

    // R2 register layout and read-back
    for (int i = 0; i < 6; i++) step(1, 4'(8 + i), 8'(8'h11 * (i + 1)), 0);
    for (int i = 0; i < 6; i++) readCheck(4'(8 + i), mAlm[i], "R2 alarm readback");

    // R11 unmapped indices
    step(1, 4'd0, 8'hFF, 0);
    step(1, 4'd15, 8'hFF, 0);
    readCheck(4'd0, 8'h00, "R11 index 0 reads zero");
    readCheck(4'd15, 8'h00, "R11 index 15 reads zero");
    for (int i = 0; i < 6; i++) readCheck(4'(8 + i), mAlm[i], "R11 alarms untouched");

    // R5 and R3: all bytes zero, time zero -> no alarm
    for (int i = 0; i < 6; i++) step(1, 4'(8 + i), 8'h00, 0);
    setTime(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1);
    stateCheck("R5 no fields enabled");
    // R3 bit7 clear with value equal to time still ignored
    step(1, 4'd8, 8'h25, 0);
    setTime(7'h25, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1);
    stateCheck("R3 R5 disabled field ignored");

    // R4, R3: only seconds enabled, minutes byte disabled differs
    step(1, 4'd8, 8'hB0, 0);
    step(1, 4'd9, 8'h15, 0);
    setTime(7'h30, 7'h44, 7'h12, 7'h03, 7'h21, 7'h07);
    step(0, 0, 0, 1);
    stateCheck("R4 R3 single field match");

    // R8 enable without clearing
    step(1, 4'd14, 8'h09, 0);
    stateCheck("R8 enable sets irq");
    // R7 mismatching tick keeps flag
    setTime(7'h31, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1);
    stateCheck("R7 sticky across mismatch");
    // R7 clear
    step(1, 4'd14, 8'h08, 0);
    stateCheck("R7 clear by zero");
    step(1, 4'd14, 8'h09, 0);
    stateCheck("R7 writing one does not set");

    // R6 match without tick
    setTime(7'h30, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0);
    stateCheck("R6 no tick no set");

    // R9 clear and match in the same cycle
    step(1, 4'd14, 8'h08, 1);
    stateCheck("R9 match wins over clear");
    step(1, 4'd14, 8'h00, 0);
    stateCheck("R8 disable clears irq");

    // R10 month mismatch then match
    step(1, 4'd13, 8'h92, 0);
    setTime(7'h30, 0, 0, 0, 0, 7'h11);
    step(0, 0, 0, 1);
    stateCheck("R10 month mismatch");
    tCur[5] = 7'h12;
    step(0, 0, 0, 1);
    stateCheck("R10 month 12 matches");
    step(1, 4'd14, 8'h08, 0);

    // Random mix (R4 R10 R7 R8)
    for (int it = 0; it < 400; it++) begin
      logic [6:0] tv [6];
      int lim [6] = '{60, 60, 24, 7, 31, 12};
      for (int i = 0; i < 6; i++) begin
        int base = (i >= 4) ? 1 : 0;
        tv[i] = toBcd(base + int'($urandom % lim[i]));
      end
      for (int i = 0; i < 6; i++) begin
        int r = int'($urandom % 4);
        logic [7:0] b;
        if (r == 0)      b = {1'b0, 7'($urandom)};
        else if (r == 3) b = {1'b1, toBcd(int'($urandom % 12) + 1)};
        else             b = {1'b1, tv[i]};
        step(1, 4'(8 + i), b, 0);
      end
      if (($urandom % 3) == 0) step(1, 4'd14, {4'b0, 1'($urandom), 3'b000}, 0);
      setTime(tv[0], tv[1], tv[2], tv[3], tv[4], tv[5]);
      step(0, 0, 0, 1);
      stateCheck("R4 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule